// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Controller

This block is the control logic of a nonvolatile SRAM model. It sits on an SRAM-style bus and samples that bus with a system clock: an active-low chip enable, an active-low write enable, a 13-bit address and 8-bit write and read data. Each falling edge of chip enable opens one access. The block decodes that access as a read or a write into a working SRAM array. A second array of the same depth, the shadow array, holds the copy that stands in for the nonvolatile cells.

Software starts a copy between the two arrays with a fixed signature of six reads. The sixth address picks the direction: SRAM to shadow (STORE) or shadow to SRAM (RECALL). An active-low hardware store pin also requests a STORE. That request copies only if the SRAM was written after the last copy. In either case it puts the block on hold until the pin goes high again.

Each copy moves one byte per clock and keeps `busy` high for a fixed `NV_CYCLES` clock cycles. Both arrays have `DEPTH` bytes. The low log2(`DEPTH`) address bits index them, and the upper address bits are used only to decode the signature.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, and at any time chip enable is high, `dout_en` is 0 and `dout` reads 0.
- R2: A chip-enable falling edge that is sampled with `we_n`=1 and `hs_n`=1 is a read. From the next clock `dout_en`=1 and `dout` holds the byte at address bits [log2(DEPTH)-1:0]. Both stay that way while chip enable remains low.
- R3: A chip-enable falling edge sampled with `we_n`=0 writes `din` to the addressed byte. It also clears any signature that is partly entered.
- R4: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, followed by a read at 0x0F0F start a STORE. `busy` is then high for exactly `NV_CYCLES` clock samples, starting with the clock after that sixth access.
- R5: The same five reads followed by a read at 0x0F0E start a RECALL. Once `busy` falls, every SRAM byte equals the shadow array.
- R6: The first five reads of the signature return data as normal reads. The sixth access leaves `dout_en` at 0, and `dout_en` is 0 for as long as `busy` is high.
- R7: A read at any address other than the expected next one clears the signature progress. A read at 0x0000 always counts as step one of a new signature.
- R8: A bus access that starts while `busy` is high has no effect on the SRAM.
- R9: When `hs_n` is sampled low while the block is idle, a STORE starts if any SRAM write happened since the last copy finished. If not, `busy` stays 0.
- R10: After `hs_n` is sampled low, `hold` is 1 and bus accesses are ignored until `hs_n` is high and no copy runs. `hold` then returns to 0.
- R11: A finished STORE or RECALL clears the pending-write state, so a later `hs_n` request with no new write makes no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; each falling edge is one access |
| we_n | input | 1 | Write enable, active low, sampled at the access |
| hs_n | input | 1 | Hardware store request, active low |
| addr | input | 13 | Bus address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data valid (bus would be driven) |
| busy | output | 1 | A STORE or RECALL is running |
| hold | output | 1 | Hardware-store hold, bus ignored |

## Verification
The bench uses a small array and sweeps every location with two different arithmetic byte patterns. A STORE followed by an overwrite and then a RECALL shows that both copy directions really move data and do not leave either array untouched. Signatures are sent complete with each final key, broken by a wrong address, broken by a write, and restarted in the middle with 0x0000. This separates a decoder that counts correctly from one that only matches the last address or never resets. The hardware store pin is tried with and without a prior write, so a skipped copy can be told apart from a real one. Bus accesses made during a copy and during the hold are read back afterwards to prove that they were ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int NVS_AW = 13;
  localparam int NVS_DW = 8;
  localparam logic [NVS_AW-1:0] KEY_STORE  = 13'h0F0F;
  localparam logic [NVS_AW-1:0] KEY_RECALL = 13'h0F0E;

  function automatic logic [NVS_AW-1:0] unlock_addr(input logic [2:0] step);
    case (step)
      3'd0:    return 13'h0000;
      3'd1:    return 13'h1555;
      3'd2:    return 13'h0AAA;
      3'd3:    return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/nvs_ram.sv
module nvs_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] a,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    rd <= mem[a];
  end
endmodule

// File: rtl/nvs_unlock.sv
module nvs_unlock
  import nvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [NVS_AW-1:0] addr,
  output logic              go_store,
  output logic              go_recall,
  output logic              sixth
);
  logic [2:0] step_q;

  always_comb begin
    sixth     = acc_rd && step_q == 3'd5 && (addr == KEY_STORE || addr == KEY_RECALL);
    go_store  = sixth && addr == KEY_STORE;
    go_recall = sixth && addr == KEY_RECALL;
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= 3'd0;
    else if (acc_wr) step_q <= 3'd0;
    else if (acc_rd) begin
      if (step_q < 3'd5 && addr == unlock_addr(step_q)) step_q <= step_q + 3'd1;
      else if (addr == unlock_addr(3'd0))               step_q <= 3'd1;
      else                                              step_q <= 3'd0;
    end
  end

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> step_q == 3'd0);
  a_r7_zero_restarts: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && addr == 13'h0000) |=> step_q == 3'd1);
endmodule

// File: rtl/nvs_copy.sv
module nvs_copy #(
  parameter int DEPTH     = 256,
  parameter int NV_CYCLES = 300,
  localparam int IW       = $clog2(DEPTH),
  localparam int CW       = $clog2(NV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_store,
  output logic          busy,
  output logic          op_store,
  output logic [IW-1:0] rd_idx,
  output logic          cp_v,
  output logic [IW-1:0] cp_idx,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, op_q, cp_v_q;
  logic [IW-1:0] cp_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      op_q     <= 1'b0;
      cp_v_q   <= 1'b0;
      cp_idx_q <= '0;
    end else begin
      cp_v_q   <= busy_q && cnt_q < CW'(DEPTH);
      cp_idx_q <= cnt_q[IW-1:0];
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          op_q   <= start_store;
        end
      end else if (cnt_q == CW'(NV_CYCLES - 1)) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign op_store = op_q;
  assign rd_idx   = cnt_q[IW-1:0];
  assign cp_v     = cp_v_q;
  assign cp_idx   = cp_idx_q;
  assign done     = busy_q && cnt_q == CW'(NV_CYCLES - 1);

  a_r4_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(cnt_q) == CW'(NV_CYCLES - 1));
  a_r5_copy_in_window: assert property (@(posedge clk) disable iff (rst)
    cp_v_q |-> $past(busy_q));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int NV_CYCLES = 300,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              hs_n,
  input  logic [NVS_AW-1:0] addr,
  input  logic [NVS_DW-1:0] din,
  output logic [NVS_DW-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              hold
);
  logic ce_q, lock_q, dirty_q, oe_q;
  logic fall, open_bus, acc_rd, acc_wr, hs_trig;
  logic go_store, go_recall, sixth, start, start_store;
  logic cbusy, op_store, cp_v, done;
  logic [IW-1:0] rd_idx, cp_idx, bus_idx;
  logic [IW-1:0] sram_a, shd_a;
  logic          sram_we, shd_we;
  logic [NVS_DW-1:0] sram_wd, sram_rd, shd_rd;

  assign bus_idx  = addr[IW-1:0];
  assign fall     = ce_q && !ce_n;
  assign open_bus = !cbusy && !lock_q && hs_n;
  assign acc_rd   = fall && open_bus && we_n;
  assign acc_wr   = fall && open_bus && !we_n;
  assign hs_trig  = !hs_n && !lock_q && !cbusy;
  assign start_store = go_store || (hs_trig && dirty_q);
  assign start       = start_store || go_recall;

  nvs_unlock u_unlock (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .addr(addr),
    .go_store(go_store), .go_recall(go_recall), .sixth(sixth)
  );

  nvs_copy #(.DEPTH(DEPTH), .NV_CYCLES(NV_CYCLES)) u_copy (
    .clk(clk), .rst(rst), .start(start), .start_store(start_store),
    .busy(cbusy), .op_store(op_store), .rd_idx(rd_idx), .cp_v(cp_v),
    .cp_idx(cp_idx), .done(done)
  );

  always_comb begin
    if (cbusy) begin
      sram_a  = op_store ? rd_idx : cp_idx;
      sram_we = !op_store && cp_v;
      sram_wd = shd_rd;
    end else begin
      sram_a  = bus_idx;
      sram_we = acc_wr;
      sram_wd = din;
    end
    shd_a  = op_store ? cp_idx : rd_idx;
    shd_we = cbusy && op_store && cp_v;
  end

  nvs_ram #(.W(NVS_DW), .DEPTH(DEPTH)) u_sram (
    .clk(clk), .we(sram_we), .a(sram_a), .wd(sram_wd), .rd(sram_rd)
  );
  nvs_ram #(.W(NVS_DW), .DEPTH(DEPTH)) u_shadow (
    .clk(clk), .we(shd_we), .a(shd_a), .wd(sram_rd), .rd(shd_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q    <= 1'b1;
      lock_q  <= 1'b0;
      dirty_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (hs_trig) lock_q <= 1'b1;
      else if (lock_q && hs_n && !cbusy) lock_q <= 1'b0;
      if (done) dirty_q <= 1'b0;
      else if (acc_wr) dirty_q <= 1'b1;
      if (acc_rd && !sixth) oe_q <= 1'b1;
      else if (ce_n || cbusy || lock_q || !hs_n) oe_q <= 1'b0;
    end
  end

  assign dout    = oe_q ? sram_rd : '0;
  assign dout_en = oe_q;
  assign busy    = cbusy;
  assign hold    = lock_q;

  a_r6_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    cbusy |-> !oe_q);
  a_r9_clean_skip: assert property (@(posedge clk) disable iff (rst)
    (hs_trig && !dirty_q) |=> !cbusy);
  a_r10_hold_stays: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !hs_n) |=> lock_q);
  a_r11_done_clears: assert property (@(posedge clk) disable iff (rst)
    done |=> !dirty_q);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (ce_n && $past(ce_n)) |-> !oe_q);
endmodule

// File: tb/nvs_ctrl_tb.sv
module nvs_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int NVC   = 20;

  logic clk = 1'b0;
  logic rst, ce_n, we_n, hs_n, dout_en, busy, hold;
  logic [12:0] addr;
  logic [7:0]  din, dout;
  logic [7:0]  exp_s [DEPTH];
  logic [7:0]  exp_h [DEPTH];
  int total = 0, bad = 0;
  logic last_oe, last_busy;
  logic [7:0] last_do;

  always #(CLK_P/2) clk = ~clk;

  nvs_ctrl #(.DEPTH(DEPTH), .NV_CYCLES(NVC)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .hs_n(hs_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .hold(hold)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bus(input logic [12:0] a, input logic wr, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = !wr; addr = a; din = d;
    @(negedge clk);
    last_oe = dout_en; last_do = dout; last_busy = busy;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [12:0] a, input string req);
    bus(a, 1'b0, 8'h00);
    check({req, " oe"}, int'(last_oe), 1);
    check({req, " data"}, int'(last_do), int'(exp_s[a[3:0]]));
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    bus(a, 1'b1, d);
    exp_s[a[3:0]] = d;
  endtask

  task automatic count_busy(input string req);
    int n = int'(last_busy);
    while (1) begin
      @(negedge clk);
      if (busy) n++; else break;
    end
    check(req, n, NVC);
  endtask

  task automatic prefix(input string req);
    rd_chk(13'h0000, req); rd_chk(13'h1555, req); rd_chk(13'h0AAA, req);
    rd_chk(13'h1FFF, req); rd_chk(13'h10F0, req);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < DEPTH; i++) rd_chk(13'(i + 16 * i), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; hs_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 reset oe", int'(dout_en), 0);
    check("R1 reset dout", int'(dout), 0);
    check("R4 reset busy", int'(busy), 0);
    check("R10 reset hold", int'(hold), 0);

    // R2 R3: fill pattern A, sweep back
    for (int i = 0; i < DEPTH; i++) wr(13'(i), 8'((i * 29 + 7) & 8'hFF));
    @(negedge clk);
    check("R1 ce high oe", int'(dout_en), 0);
    sweep("R2");

    // R4 R6: store
    prefix("R6");
    bus(13'h0F0F, 1'b0, 8'h00);
    check("R6 sixth quiet", int'(last_oe), 0);
    count_busy("R4 busy length");
    for (int i = 0; i < DEPTH; i++) exp_h[i] = exp_s[i];

    // pattern B, then recall with a write during busy (R8)
    for (int i = 0; i < DEPTH; i++) wr(13'(i), 8'((i * 53 + 200) & 8'hFF));
    sweep("R3");
    prefix("R5");
    bus(13'h0F0E, 1'b0, 8'h00);
    check("R5 recall busy", int'(last_busy), 1);
    bus(13'h0003, 1'b1, 8'hEE);
    check("R6 oe during busy", int'(dout_en), 0);
    while (busy) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) exp_s[i] = exp_h[i];
    sweep("R5 R8");

    // R7: wrong address breaks the signature
    rd_chk(13'h0000, "R7"); rd_chk(13'h1555, "R7"); rd_chk(13'h0AAA, "R7");
    rd_chk(13'h0005, "R7"); rd_chk(13'h1FFF, "R7"); rd_chk(13'h10F0, "R7");
    rd_chk(13'h0F0F, "R7 broken key reads");
    check("R7 no busy", int'(busy), 0);
    // R7: restart at 0x0000 mid-sequence
    rd_chk(13'h0000, "R7"); rd_chk(13'h1555, "R7");
    prefix("R7");
    bus(13'h0F0E, 1'b0, 8'h00);
    check("R7 restart busy", int'(last_busy), 1);
    while (busy) @(negedge clk);

    // R3: write aborts signature
    rd_chk(13'h0000, "R3"); rd_chk(13'h1555, "R3");
    wr(13'h0006, 8'h5A);
    rd_chk(13'h0AAA, "R3"); rd_chk(13'h1FFF, "R3"); rd_chk(13'h10F0, "R3");
    rd_chk(13'h0F0F, "R3 aborted key reads");
    check("R3 no busy", int'(busy), 0);

    // R11: store clears dirty
    prefix("R11");
    bus(13'h0F0F, 1'b0, 8'h00);
    while (busy) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) exp_h[i] = exp_s[i];
    @(negedge clk) hs_n = 1'b0;
    @(negedge clk);
    check("R9 R11 clean skip", int'(busy), 0);
    check("R10 hold set", int'(hold), 1);
    bus(13'h0002, 1'b1, 8'h99);
    bus(13'h0002, 1'b0, 8'h00);
    check("R10 read ignored", int'(last_oe), 0);
    @(negedge clk) hs_n = 1'b1;
    @(negedge clk);
    check("R10 hold released", int'(hold), 0);
    rd_chk(13'h0002, "R10 write ignored");

    // R9: dirty hardware store
    wr(13'h0004, 8'h44);
    @(negedge clk) hs_n = 1'b0;
    @(negedge clk);
    last_busy = busy;
    count_busy("R9 store length");
    check("R10 hold after store", int'(hold), 1);
    @(negedge clk) hs_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) exp_h[i] = exp_s[i];
    wr(13'h0004, 8'h00);
    prefix("R9");
    bus(13'h0F0E, 1'b0, 8'h00);
    while (busy) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) exp_s[i] = exp_h[i];
    rd_chk(13'h0004, "R9 stored byte");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule